// File: doc/BRIEF.md
# Bit-Serial Binary-to-Decimal Converter

This block turns an unsigned binary reading into packed BCD digits for a character display. A typical source is a scaled converter sample that stands for a fixed-point voltage with one fractional decimal digit. The reading can first be multiplied by a small integer gain. The multiply works by adding the reading into an accumulator once for each count of the gain. The result is then split into decimal digits by dividing it by ten again and again. Each division subtracts ten until fewer than ten remain. The number of subtractions is the quotient and the leftover is the digit, least significant first.

Every addition and subtraction goes through one single-bit adder/subtractor cell with a carry/borrow flop. A pass stops as soon as no carry or borrow is still moving and no operand bits remain. Conversion time therefore depends on the data. The caller starts a conversion with a one-cycle pulse on `start_i`. The converter takes a request only while `busy_o` is low. A pulse that arrives while it is busy is dropped, with no queue and no back-pressure. Results appear on `digits_o`, `blank_o` and `dp_o` together with a one-cycle `done_o`. They are held until the next completion.

Top module: `serial_dec_conv`

## Requirements
- R1: A synchronous active-high reset leaves `busy_o`, `done_o`, `digits_o` and `blank_o` all at zero, including when it is applied in the middle of a conversion.
- R2: A `start_i` pulse seen while `busy_o` is low is accepted. `busy_o` is high from the next cycle until completion.
- R3: Each accepted start produces exactly one `done_o` pulse, one cycle wide. `busy_o` falls in that same cycle.
- R4: A `start_i` pulse while `busy_o` is high is ignored. The result reflects the first request and no extra `done_o` follows.
- R5: At `done_o`, `digits_o` holds the decimal digits of the scaled value. Digit i sits in bits [4i+3:4i], digit 0 is least significant, and each code is a BCD value from 0 to 9. Values 0, 9, 10 and 65535 are converted exactly.
- R6: The scaled value is `data_i * gain_i`. A gain of 1 passes the reading through unchanged and a gain of 0 yields all-zero digits.
- R7: `blank_o[i]` is 1 exactly when i is greater than DP_POS and digit i and every more significant digit are zero.
- R8: `dp_o` has a single 1 at bit DP_POS (default 1), meaning the point lies between digit DP_POS and digit DP_POS-1. This leaves one fractional digit.
- R9: `digits_o` and `blank_o` do not change while `busy_o` is high. The previous result stays visible during a new conversion.
- R10: A start pulse that arrives in the same cycle as `done_o` is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to convert |
| data_i | input | DATA_W (16) | Unsigned binary reading, sampled on an accepted start |
| gain_i | input | GAIN_W (4) | Integer scale factor, sampled with the reading |
| busy_o | output | 1 | Conversion in progress; requests are dropped while high |
| done_o | output | 1 | One-cycle pulse when a new result is published |
| digits_o | output | NUM_DIG*4 (28) | Packed BCD digits, digit 0 in the low nibble |
| blank_o | output | NUM_DIG (7) | Leading-zero blanking flags per digit |
| dp_o | output | NUM_DIG (7) | Decimal point position marker |

## Verification
The completion pulse and the acceptance of a new request can land in the same cycle. The bench provokes this by raising `start_i` at the very sampling point where it first sees `done_o` high. The next cycle must show `busy_o` high while the old digits are still held. The second completion must then carry the new value. The bench also sends a second request in the middle of a conversion and checks that the digits match the first reading and that no second `done_o` appears.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MTEST,
    ST_ADD,
    ST_DTEST,
    ST_SUB,
    ST_FIN
  } sdc_state_t;

  // Number of decimal digits needed for the largest w-bit unsigned value.
  function automatic int dec_digits(input int w);
    longint unsigned v;
    int n;
    v = (longint'(1) << w) - 1;
    n = 1;
    v = v / 10;
    while (v != 0) begin
      n = n + 1;
      v = v / 10;
    end
    return n;
  endfunction

endpackage

// File: rtl/sdc_serial_alu.sv
module sdc_serial_alu (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic sub_mode,
  input  logic a_bit,
  input  logic b_bit,
  output logic res_bit,
  output logic cy_next
);

  logic cy_q;

  always_comb begin
    res_bit = a_bit ^ b_bit ^ cy_q;
    if (sub_mode)
      cy_next = (~a_bit & b_bit) | (~(a_bit ^ b_bit) & cy_q);
    else
      cy_next = (a_bit & b_bit) | ((a_bit ^ b_bit) & cy_q);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      cy_q <= 1'b0;
    else if (en)
      cy_q <= cy_next;
  end

endmodule

// File: rtl/sdc_digit_bank.sv
module sdc_digit_bank #(
  parameter int NUM_DIG = 7,
  parameter int IDX_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   we,
  input  logic [IDX_W-1:0]       widx,
  input  logic [3:0]             wdata,
  output logic [NUM_DIG*4-1:0]   q
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (we) begin
      for (int i = 0; i < NUM_DIG; i++) begin
        if (widx == IDX_W'(i))
          q[i*4 +: 4] <= wdata;
      end
    end
  end

endmodule

// File: rtl/sdc_blank_mask.sv
module sdc_blank_mask #(
  parameter int NUM_DIG = 7,
  parameter int DP_POS  = 1
) (
  input  logic [NUM_DIG*4-1:0] digits,
  output logic [NUM_DIG-1:0]   blank
);

  logic [NUM_DIG:0] zero_from;

  assign zero_from[NUM_DIG] = 1'b1;

  for (genvar g = NUM_DIG - 1; g >= 0; g--) begin : g_digit
    assign zero_from[g] = (digits[g*4 +: 4] == 4'd0) & zero_from[g+1];
    if (g > DP_POS) begin : g_lead
      assign blank[g] = zero_from[g];
    end else begin : g_keep
      assign blank[g] = 1'b0;
    end
  end

endmodule

// File: rtl/serial_dec_conv.sv
module serial_dec_conv #(
  parameter  int DATA_W  = 16,
  parameter  int GAIN_W  = 4,
  parameter  int DP_POS  = 1,
  localparam int ACC_W   = DATA_W + GAIN_W,
  localparam int NUM_DIG = sdc_pkg::dec_digits(ACC_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic [GAIN_W-1:0]    gain_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [NUM_DIG*4-1:0] digits_o,
  output logic [NUM_DIG-1:0]   blank_o,
  output logic [NUM_DIG-1:0]   dp_o
);

  import sdc_pkg::*;

  localparam int BPOS_W = $clog2(ACC_W);
  localparam int DIDX_W = (NUM_DIG > 1) ? $clog2(NUM_DIG) : 1;
  localparam logic [ACC_W-1:0] TEN_EXT = ACC_W'(10);

  sdc_state_t          state;
  logic [ACC_W-1:0]    val;
  logic [ACC_W-1:0]    quot;
  logic [DATA_W-1:0]   opnd;
  logic [GAIN_W-1:0]   mcnt;
  logic [BPOS_W-1:0]   bpos;
  logic [DIDX_W-1:0]   didx;
  logic                busy_q;
  logic                done_q;
  logic [NUM_DIG*4-1:0] digits_q;
  logic [NUM_DIG-1:0]  blank_q;

  logic [ACC_W-1:0]    opnd_ext;
  logic                alu_a, alu_b, alu_res, alu_cy;
  logic                alu_en, alu_clr, alu_sub;
  logic                add_last, sub_last, below_ten;
  logic                bank_we, bank_clr;
  logic [NUM_DIG*4-1:0] bank_q;
  logic [NUM_DIG-1:0]  blank_mask;

  assign opnd_ext  = ACC_W'(opnd);
  assign alu_sub   = (state == ST_SUB);
  assign alu_en    = (state == ST_ADD) || (state == ST_SUB);
  assign alu_clr   = (state == ST_MTEST) || (state == ST_DTEST);
  assign alu_a     = val[bpos];
  assign alu_b     = alu_sub ? TEN_EXT[bpos] : opnd_ext[bpos];
  assign below_ten = (val < TEN_EXT);

  // A pass ends once the operand is exhausted and nothing is rippling.
  assign add_last = ((bpos >= BPOS_W'(DATA_W - 1)) && !alu_cy) ||
                    (bpos == BPOS_W'(ACC_W - 1));
  assign sub_last = ((bpos >= BPOS_W'(3)) && !alu_cy) ||
                    (bpos == BPOS_W'(ACC_W - 1));

  assign bank_clr = (state == ST_IDLE) && start_i;
  assign bank_we  = (state == ST_DTEST) && below_ten;

  sdc_serial_alu u_alu (
    .clk      (clk),
    .rst      (rst),
    .clr      (alu_clr),
    .en       (alu_en),
    .sub_mode (alu_sub),
    .a_bit    (alu_a),
    .b_bit    (alu_b),
    .res_bit  (alu_res),
    .cy_next  (alu_cy)
  );

  sdc_digit_bank #(
    .NUM_DIG (NUM_DIG),
    .IDX_W   (DIDX_W)
  ) u_bank (
    .clk   (clk),
    .rst   (rst),
    .clr   (bank_clr),
    .we    (bank_we),
    .widx  (didx),
    .wdata (val[3:0]),
    .q     (bank_q)
  );

  sdc_blank_mask #(
    .NUM_DIG (NUM_DIG),
    .DP_POS  (DP_POS)
  ) u_blank (
    .digits (bank_q),
    .blank  (blank_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      val      <= '0;
      quot     <= '0;
      opnd     <= '0;
      mcnt     <= '0;
      bpos     <= '0;
      didx     <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      digits_q <= '0;
      blank_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            opnd   <= data_i;
            mcnt   <= gain_i;
            val    <= '0;
            quot   <= '0;
            didx   <= '0;
            busy_q <= 1'b1;
            state  <= ST_MTEST;
          end
        end
        ST_MTEST: begin
          bpos  <= '0;
          state <= (mcnt == '0) ? ST_DTEST : ST_ADD;
        end
        ST_ADD: begin
          val[bpos] <= alu_res;
          if (add_last) begin
            mcnt  <= mcnt - 1'b1;
            state <= ST_MTEST;
          end else begin
            bpos <= bpos + 1'b1;
          end
        end
        ST_DTEST: begin
          bpos <= '0;
          if (below_ten) begin
            if ((didx == DIDX_W'(NUM_DIG - 1)) || (quot == '0)) begin
              state <= ST_FIN;
            end else begin
              val  <= quot;
              quot <= '0;
              didx <= didx + 1'b1;
            end
          end else begin
            state <= ST_SUB;
          end
        end
        ST_SUB: begin
          val[bpos] <= alu_res;
          if (sub_last) begin
            quot  <= quot + 1'b1;
            state <= ST_DTEST;
          end else begin
            bpos <= bpos + 1'b1;
          end
        end
        ST_FIN: begin
          digits_q <= bank_q;
          blank_q  <= blank_mask;
          done_q   <= 1'b1;
          busy_q   <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_dp
    assign dp_o[g] = (DP_POS > 0) && (g == DP_POS);
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign digits_o = digits_q;
  assign blank_o  = blank_q;

endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
  parameter int NUM_DIG = 7,
  parameter int DP_POS  = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start_i,
  input logic                 busy_o,
  input logic                 done_o,
  input logic [NUM_DIG*4-1:0] digits_o,
  input logic [NUM_DIG-1:0]   blank_o
);

  function automatic logic all_bcd(input logic [NUM_DIG*4-1:0] d);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NUM_DIG; i++)
      if (d[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic blanks_zero(input logic [NUM_DIG*4-1:0] d,
                                       input logic [NUM_DIG-1:0]   b);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NUM_DIG; i++)
      if (b[i] && (d[i*4 +: 4] != 4'd0)) ok = 1'b0;
    return ok;
  endfunction

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r5_bcd_codes: assert property (@(posedge clk) disable iff (rst)
    done_o |-> all_bcd(digits_o));

  a_r7_blank_only_zero: assert property (@(posedge clk) disable iff (rst)
    done_o |-> blanks_zero(digits_o, blank_o));

  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> ($stable(digits_o) && $stable(blank_o)));

endmodule

bind serial_dec_conv sdc_checker #(
  .NUM_DIG (NUM_DIG),
  .DP_POS  (DP_POS)
) u_sdc_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .digits_o (digits_o),
  .blank_o  (blank_o)
);

// File: tb/serial_dec_conv_test.sv
module serial_dec_conv_test;

  localparam int ND  = 7;
  localparam int DPP = 1;
  localparam int NV  = 10;

  // {reading, gain}
  localparam logic [19:0] VEC [NV] = '{
    {16'd0,     4'd1},
    {16'd9,     4'd1},
    {16'd10,    4'd1},
    {16'd65535, 4'd1},
    {16'd1234,  4'd5},
    {16'd99,    4'd0},
    {16'd100,   4'd1},
    {16'd409,   4'd15},
    {16'd19,    4'd2},
    {16'd7,     4'd15}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [15:0]   data = '0;
  logic [3:0]    gain = '0;
  logic          busy, done;
  logic [ND*4-1:0] digits;
  logic [ND-1:0] blank, dp;

  int tests = 0;
  int fails = 0;

  serial_dec_conv uut (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .data_i   (data),
    .gain_i   (gain),
    .busy_o   (busy),
    .done_o   (done),
    .digits_o (digits),
    .blank_o  (blank),
    .dp_o     (dp)
  );

  function automatic logic [ND*4-1:0] ref_dig(input int unsigned v);
    logic [ND*4-1:0] r;
    int unsigned x;
    x = v;
    for (int i = 0; i < ND; i++) begin
      r[i*4 +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic logic [ND-1:0] ref_blank(input logic [ND*4-1:0] d);
    logic [ND-1:0] r;
    logic z;
    z = 1'b1;
    for (int i = ND - 1; i >= 0; i--) begin
      z = z && (d[i*4 +: 4] == 4'd0);
      r[i] = (i > DPP) && z;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [15:0] d, input logic [3:0] g);
    @(negedge clk);
    data  = d;
    gain  = g;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic check_result(input int unsigned value);
    logic [ND*4-1:0] e;
    e = ref_dig(value);
    chk("R5/R6 digits", 64'(digits), 64'(e));
    chk("R7 blanking", 64'(blank), 64'(ref_blank(e)));
    chk("R8 point", 64'(dp), 64'(1 << DPP));
  endtask

  task automatic run_one(input logic [15:0] d, input logic [3:0] g);
    pulse_start(d, g);
    chk("R2 busy after start", 64'(busy), 64'd1);
    wait_done();
    check_result(int'(d) * int'(g));
    @(negedge clk);
    chk("R3 done one cycle", 64'(done), 64'd0);
    chk("R3 busy cleared", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int done_seen;
    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 digits", 64'(digits), 64'd0);
    chk("R1 blank", 64'(blank), 64'd0);

    // Vector table: R5, R6, R7, R8
    for (int k = 0; k < NV; k++)
      run_one(VEC[k][19:4], VEC[k][3:0]);

    // Random readings
    for (int k = 0; k < 12; k++)
      run_one(16'($urandom_range(2000, 0)), 4'($urandom_range(3, 1)));

    // R4: start while busy is ignored
    pulse_start(16'd1500, 4'd1);
    repeat (10) @(negedge clk);
    data = 16'd777; gain = 4'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R4 first request kept", 64'(digits), 64'(ref_dig(1500)));
    done_seen = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (done) done_seen++;
    end
    chk("R4 no extra done", 64'(done_seen), 64'd0);
    chk("R4 idle afterwards", 64'(busy), 64'd0);

    // R10 + R9: start in the done cycle, old result held while busy
    pulse_start(16'd321, 4'd2);
    wait_done();
    chk("R10 first result", 64'(digits), 64'(ref_dig(642)));
    data = 16'd58; gain = 4'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 accepted in done cycle", 64'(busy), 64'd1);
    chk("R9 old digits held", 64'(digits), 64'(ref_dig(642)));
    wait_done();
    check_result(174);

    // R1: reset mid-conversion
    pulse_start(16'd60000, 4'd1);
    repeat (50) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid reset busy", 64'(busy), 64'd0);
    chk("R1 mid reset digits", 64'(digits), 64'd0);
    done_seen = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (done) done_seen++;
    end
    chk("R1 no done after reset", 64'(done_seen), 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule